// File: doc/BRIEF.md
# Memory Access Protection Rule Checker

This block sits in front of a multi-port memory controller and decides, for every transaction offered to it, whether the access may proceed. It holds a table of twenty protection rules. Each rule combines an address window with 1 MiB granularity, an inclusive range of 12-bit master IDs, a mask of source ports and a security filter, and it carries a verdict of accept or reject. All rules are compared in parallel. When several valid rules match, the lowest-numbered one decides. A per-port default register decides accesses that no valid rule matches.

Software reaches the rules only through a small indirect window. There are three staging registers (range, ID range, flags) and a select register. The select register holds the rule number and two self-clearing strobes: one copies the staging registers into the selected rule, and one loads the selected rule back into the staging registers. Software can read back every register of the window, and the default register, directly.

Transactions arrive on a valid/ready request channel, and the verdict leaves on a valid/ready response channel. The response register can hold one verdict. The request side is ready whenever that register is empty or is being drained in the same cycle. While `resp_valid` is high and `resp_ready` is low, the verdict is held unchanged and no new request is taken. A request accepted at a clock edge produces its verdict on the outputs right after that edge.

Top module: `mem_prot_checker`

## Requirements
- R1: The select register is window offset 0. Its rule number is in bits [4:0]. Writing it with bit 5 set copies the range, ID and flags staging registers into that rule at the following clock edge. A rule number of 20 or more makes the copy a no-op.
- R2: Writing the select register with bit 6 set loads the selected rule into the three staging registers at the following clock edge. The loaded value wins over a staging write at the same edge, and a rule number of 20 or more leaves the staging registers unchanged. The strobe bits read back as 1 for exactly one cycle after the write and then read 0. Offset 0 reads back as {25'b0, bit6, bit5, number}.
- R3: The range register is offset 1, with the first megabyte in bits [11:0] and the last megabyte in bits [23:12]. A rule covers an address when address bits [31:20] lie between these two values, with both ends included.
- R4: The ID register is offset 2, with the lowest ID in bits [11:0] and the highest ID in bits [23:12]. A rule covers a master ID in that inclusive range.
- R5: The flags register is offset 3. Bits [1:0] form the security filter: bit 0 admits secure accesses and bit 1 admits non-secure accesses. Bit 2 is the valid bit. Bits [12:3] form the port mask, where bit 3+p admits port p. Bit 13 is the verdict: 1 rejects and 0 accepts.
- R6: When several valid rules cover an access, the lowest-numbered one sets `resp_reject`. The response then raises `resp_hit` with `resp_rule` equal to that rule's number. On a miss, `resp_hit` is 0 and `resp_rule` is 0.
- R7: The default register is offset 4, bits [9:0]. An access that no rule covers is rejected when the bit of its port is 1 and accepted when that bit is 0. A port number of 10 or more matches no rule and is always rejected.
- R8: Reset clears all rules, the staging, select and default registers and the response. Afterwards every access is accepted with no hit, and all window registers read 0.
- R9: A request is taken at an edge where `txn_valid` and `txn_ready` are both high, and its verdict appears with `resp_valid` right after that edge. `txn_ready` equals not `resp_valid` or `resp_ready`. The verdict stays stable while `resp_ready` is low.
- R10: A rule whose valid bit is 0 never matches, so copying all-zero staging registers into a rule removes it from the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register window write enable |
| reg_addr | input | 3 | Register window offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| txn_valid | input | 1 | Request valid |
| txn_ready | output | 1 | Request ready |
| txn_addr | input | 32 | Request byte address |
| txn_id | input | 12 | Request master ID |
| txn_port | input | 4 | Request source port number |
| txn_secure | input | 1 | 1 for a secure access, 0 for a non-secure access |
| resp_valid | output | 1 | Verdict valid |
| resp_ready | input | 1 | Verdict consumed |
| resp_reject | output | 1 | 1 rejects the access, 0 accepts it |
| resp_hit | output | 1 | A rule decided the access |
| resp_rule | output | 5 | Number of the deciding rule, 0 on a miss |

## Verification
A rule stored wrongly shows at the ports in two ways. It gives a wrong verdict, hit flag or rule number on the first request it covers, one edge after that request is taken. It also reads back wrongly through the staging registers one edge after a read strobe. A stuck or repeated strobe shows in the select readback on the second cycle after the write, and it can overwrite a rule or the staging registers unasked. A broken handshake register shows up as a verdict that changes under back-pressure, or as a request taken while the response is blocked.

// File: rtl/mem_prot_pkg.sv
package mem_prot_pkg;
  localparam int unsigned PAGE_W  = 12;
  localparam int unsigned ID_W    = 12;
  localparam int unsigned PORT_N  = 10;
  localparam int unsigned SEC_W   = 2;
  localparam int unsigned FLAGS_W = SEC_W + 1 + PORT_N + 1;

  // packed so that {range, ids, flags} staging registers map straight onto it
  typedef struct packed {
    logic [PAGE_W-1:0] pg_hi;
    logic [PAGE_W-1:0] pg_lo;
    logic [ID_W-1:0]   id_hi;
    logic [ID_W-1:0]   id_lo;
    logic              deny;
    logic [PORT_N-1:0] pmask;
    logic              vld;
    logic [SEC_W-1:0]  sec;
  } rule_t;

  typedef enum logic [2:0] {
    RG_SEL   = 3'd0,
    RG_RANGE = 3'd1,
    RG_IDS   = 3'd2,
    RG_FLAGS = 3'd3,
    RG_DFLT  = 3'd4
  } win_reg_e;
endpackage

// File: rtl/mem_prot_regs.sv
module mem_prot_regs
  import mem_prot_pkg::*;
#(
  parameter int unsigned NRULES = 20,
  parameter int unsigned SEL_W  = $clog2(NRULES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [2:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output rule_t [NRULES-1:0]       rules_o,
  output logic [PORT_N-1:0]        dflt_o,
  output logic                     wr_go_o
);
  localparam int unsigned RNG_W = 2 * PAGE_W;
  localparam int unsigned IDS_W = 2 * ID_W;

  logic [SEL_W-1:0]   sel;
  logic               wr_go, rd_go;
  logic [RNG_W-1:0]   st_range;
  logic [IDS_W-1:0]   st_ids;
  logic [FLAGS_W-1:0] st_flags;
  logic               sel_ok;
  rule_t              rd_rule;

  assign sel_ok  = 32'(sel) < NRULES;
  assign rd_rule = sel_ok ? rules_o[sel] : '0;
  assign wr_go_o = wr_go;

  // rule storage: written only by the copy strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rules_o <= '0;
    end else if (wr_go && sel_ok) begin
      for (int i = 0; i < int'(NRULES); i++)
        if (sel == SEL_W'(i)) rules_o[i] <= {st_range, st_ids, st_flags};
    end
  end

  // window registers; strobes live for one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= '0;
      wr_go    <= 1'b0;
      rd_go    <= 1'b0;
      st_range <= '0;
      st_ids   <= '0;
      st_flags <= '0;
      dflt_o   <= '0;
    end else begin
      wr_go <= 1'b0;
      rd_go <= 1'b0;
      if (reg_wr_en) begin
        case (reg_addr)
          RG_SEL: begin
            sel   <= reg_wdata[SEL_W-1:0];
            wr_go <= reg_wdata[SEL_W];
            rd_go <= reg_wdata[SEL_W+1];
          end
          RG_RANGE: st_range <= reg_wdata[RNG_W-1:0];
          RG_IDS:   st_ids   <= reg_wdata[IDS_W-1:0];
          RG_FLAGS: st_flags <= reg_wdata[FLAGS_W-1:0];
          RG_DFLT:  dflt_o   <= reg_wdata[PORT_N-1:0];
          default: ;
        endcase
      end
      if (rd_go && sel_ok) begin
        st_range <= {rd_rule.pg_hi, rd_rule.pg_lo};
        st_ids   <= {rd_rule.id_hi, rd_rule.id_lo};
        st_flags <= {rd_rule.deny, rd_rule.pmask, rd_rule.vld, rd_rule.sec};
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RG_SEL:   reg_rdata = 32'({rd_go, wr_go, sel});
      RG_RANGE: reg_rdata = 32'(st_range);
      RG_IDS:   reg_rdata = 32'(st_ids);
      RG_FLAGS: reg_rdata = 32'(st_flags);
      RG_DFLT:  reg_rdata = 32'(dflt_o);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mem_prot_match.sv
module mem_prot_match
  import mem_prot_pkg::*;
#(
  parameter int unsigned NRULES = 20,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PORT_W = 4
) (
  input  rule_t [NRULES-1:0]  rules,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [ID_W-1:0]     id,
  input  logic [PORT_W-1:0]   port,
  input  logic                secure,
  output logic [NRULES-1:0]   hit,
  output logic [NRULES-1:0]   deny
);
  logic [PAGE_W-1:0] page;
  logic              port_ok;

  assign page    = addr[ADDR_W-1 -: PAGE_W];
  assign port_ok = 32'(port) < PORT_N;

  for (genvar i = 0; i < int'(NRULES); i++) begin : g_rule
    logic in_pg, in_id, in_port, in_sec;
    assign in_pg   = (page >= rules[i].pg_lo) && (page <= rules[i].pg_hi);
    assign in_id   = (id >= rules[i].id_lo) && (id <= rules[i].id_hi);
    assign in_port = port_ok && rules[i].pmask[port];
    assign in_sec  = secure ? rules[i].sec[0] : rules[i].sec[1];
    assign hit[i]  = rules[i].vld && in_pg && in_id && in_port && in_sec;
    assign deny[i] = rules[i].deny;
  end
endmodule

// File: rtl/mem_prot_pick.sv
module mem_prot_pick #(
  parameter int unsigned NRULES = 20,
  parameter int unsigned IDX_W  = $clog2(NRULES)
) (
  input  logic [NRULES-1:0] hit,
  input  logic [NRULES-1:0] deny,
  output logic              any,
  output logic [IDX_W-1:0]  idx,
  output logic [NRULES-1:0] grant,
  output logic              deny_sel
);
  // lowest set bit isolated arithmetically; index found by a scan
  assign grant    = hit & (~hit + NRULES'(1));
  assign deny_sel = |(grant & deny);
  assign any      = |hit;

  always_comb begin
    idx = '0;
    for (int i = int'(NRULES) - 1; i >= 0; i--)
      if (hit[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/mem_prot_checker.sv
module mem_prot_checker
  import mem_prot_pkg::*;
#(
  parameter int unsigned NRULES = 20,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PORT_W = 4,
  parameter int unsigned IDX_W  = $clog2(NRULES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [ID_W-1:0]   txn_id,
  input  logic [PORT_W-1:0] txn_port,
  input  logic              txn_secure,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_reject,
  output logic              resp_hit,
  output logic [IDX_W-1:0]  resp_rule
);
  rule_t [NRULES-1:0] rules;
  logic [PORT_N-1:0]  dflt;
  logic               wr_go;
  logic [NRULES-1:0]  hit, deny, grant;
  logic               any, deny_sel, miss_deny, fire;
  logic [IDX_W-1:0]   idx;

  mem_prot_regs #(.NRULES(NRULES), .SEL_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rules_o(rules),
    .dflt_o(dflt), .wr_go_o(wr_go)
  );

  mem_prot_match #(.NRULES(NRULES), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_match (
    .rules(rules), .addr(txn_addr), .id(txn_id), .port(txn_port),
    .secure(txn_secure), .hit(hit), .deny(deny)
  );

  mem_prot_pick #(.NRULES(NRULES), .IDX_W(IDX_W)) u_pick (
    .hit(hit), .deny(deny), .any(any), .idx(idx), .grant(grant), .deny_sel(deny_sel)
  );

  assign miss_deny = (32'(txn_port) < PORT_N) ? dflt[txn_port] : 1'b1;
  assign txn_ready = !resp_valid || resp_ready;
  assign fire      = txn_valid && txn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_reject <= 1'b0;
      resp_hit    <= 1'b0;
      resp_rule   <= '0;
    end else if (fire) begin
      resp_valid  <= 1'b1;
      resp_reject <= any ? deny_sel : miss_deny;
      resp_hit    <= any;
      resp_rule   <= any ? idx : '0;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_prot_checker_sva.sv
module mem_prot_checker_sva #(
  parameter int unsigned NRULES = 20,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_reject,
  input logic              resp_hit,
  input logic [IDX_W-1:0]  resp_rule,
  input logic [NRULES-1:0] grant,
  input logic              wr_go
);
  // R9: a verdict under back-pressure is frozen
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_reject)
      && $stable(resp_hit) && $stable(resp_rule));

  // R9: a taken request produces a verdict
  a_r9_fire_resp: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready |=> resp_valid);

  // R9: nothing is taken while a verdict is blocked
  a_r9_no_take_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !txn_ready);

  // R1: copy strobe lasts one cycle unless rewritten
  a_r1_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && !(reg_wr_en && reg_addr == 3'd0 && reg_wdata[IDX_W]) |=> !wr_go);

  // R6: at most one rule decides
  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: reported index is a real rule, zero on a miss
  a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit ? (32'(resp_rule) < NRULES) : (resp_rule == '0)));
endmodule

bind mem_prot_checker mem_prot_checker_sva #(.NRULES(NRULES), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_reject(resp_reject),
  .resp_hit(resp_hit), .resp_rule(resp_rule), .grant(grant), .wr_go(wr_go)
);

// File: tb/mem_prot_checker_tb.sv
`timescale 1ns/1ps
module mem_prot_checker_tb;
  localparam int NR = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txn_valid = 1'b0, txn_ready;
  logic [31:0] txn_addr = '0;
  logic [11:0] txn_id = '0;
  logic [3:0]  txn_port = '0;
  logic        txn_secure = 1'b0;
  logic        resp_valid, resp_ready = 1'b1, resp_reject, resp_hit;
  logic [4:0]  resp_rule;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_prot_checker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_id(txn_id),
    .txn_port(txn_port), .txn_secure(txn_secure), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_reject(resp_reject), .resp_hit(resp_hit),
    .resp_rule(resp_rule)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [61:0] m_rule [NR];
  logic [23:0] m_rng, m_ids;
  logic [13:0] m_flg;
  logic [4:0]  m_sel;
  logic        m_wg, m_rg;
  logic [9:0]  m_dflt;
  logic        m_v, m_rej, m_hit;
  logic [4:0]  m_idx;

  function automatic logic [6:0] decide(input logic [31:0] a, input logic [11:0] id,
                                         input logic [3:0] p, input logic s);
    for (int r = 0; r < NR; r++) begin
      logic [23:0] rg = m_rule[r][61:38];
      logic [23:0] ir = m_rule[r][37:14];
      logic [13:0] fl = m_rule[r][13:0];
      if (fl[2] && a[31:20] >= rg[11:0] && a[31:20] <= rg[23:12]
          && id >= ir[11:0] && id <= ir[23:12] && p < 10 && fl[3 + p]
          && (s ? fl[0] : fl[1]))
        return {fl[13], 1'b1, 5'(r)};
    end
    return {(p < 10) ? m_dflt[p] : 1'b1, 1'b0, 5'd0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) m_rule[r] = '0;
      m_rng = '0; m_ids = '0; m_flg = '0; m_sel = '0; m_wg = 0; m_rg = 0;
      m_dflt = '0; m_v = 0; m_rej = 0; m_hit = 0; m_idx = '0;
    end else begin
      logic [61:0] rd;
      logic rd_ok, nwg, nrg;
      if (txn_valid && (!m_v || resp_ready)) begin
        {m_rej, m_hit, m_idx} = decide(txn_addr, txn_id, txn_port, txn_secure);
        m_v = 1;
      end else if (resp_ready) m_v = 0;
      rd_ok = m_rg && m_sel < NR;
      rd = (m_sel < NR) ? m_rule[m_sel] : '0;
      if (m_wg && m_sel < NR) m_rule[m_sel] = {m_rng, m_ids, m_flg};
      nwg = 0; nrg = 0;
      if (reg_wr_en) begin
        case (reg_addr)
          3'd0: begin m_sel = reg_wdata[4:0]; nwg = reg_wdata[5]; nrg = reg_wdata[6]; end
          3'd1: m_rng = reg_wdata[23:0];
          3'd2: m_ids = reg_wdata[23:0];
          3'd3: m_flg = reg_wdata[13:0];
          3'd4: m_dflt = reg_wdata[9:0];
          default: ;
        endcase
      end
      if (rd_ok) begin m_rng = rd[61:38]; m_ids = rd[37:14]; m_flg = rd[13:0]; end
      m_wg = nwg; m_rg = nrg;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [31:0] erd;
      case (reg_addr)
        3'd0: erd = {25'b0, m_rg, m_wg, m_sel};
        3'd1: erd = {8'b0, m_rng};
        3'd2: erd = {8'b0, m_ids};
        3'd3: erd = {18'b0, m_flg};
        3'd4: erd = {22'b0, m_dflt};
        default: erd = '0;
      endcase
      chk({resp_valid, txn_ready} == {m_v, !m_v || resp_ready}, "R9", "handshake",
          {resp_valid, txn_ready}, {m_v, !m_v || resp_ready});
      if (m_v)
        chk({resp_reject, resp_hit, resp_rule} == {m_rej, m_hit, m_idx}, "R6", "model verdict",
            {resp_reject, resp_hit, resp_rule}, {m_rej, m_hit, m_idx});
      chk(reg_rdata == erd, "R2", "model readback", reg_rdata, erd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic strobe(input logic [31:0] w);
    wr(3'd0, w);
    @(negedge clk);
  endtask

  task automatic put_rule(input logic [4:0] n, input logic [23:0] rg,
                          input logic [23:0] ir, input logic [13:0] fl);
    wr(3'd1, 32'(rg)); wr(3'd2, 32'(ir)); wr(3'd3, 32'(fl));
    strobe(32'(n) | 32'h20);
  endtask

  task automatic send(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                      input logic s, input logic er, input logic eh, input logic [4:0] ei,
                      input string tag);
    @(negedge clk);
    txn_addr = a; txn_id = id; txn_port = p; txn_secure = s; txn_valid = 1;
    while (!txn_ready) @(negedge clk);
    @(posedge clk); #2;
    chk(resp_valid && {resp_reject, resp_hit, resp_rule} == {er, eh, ei}, tag, "verdict",
        {resp_valid, resp_reject, resp_hit, resp_rule}, {1'b1, er, eh, ei});
    @(negedge clk);
    txn_valid = 0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; #1;
    chk(reg_rdata == e, tag, "readback", reg_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state
    for (int a = 0; a < 5; a++) rdchk(3'(a), 32'h0, "R8");
    chk(!resp_valid && txn_ready, "R8", "idle outputs", {resp_valid, txn_ready}, 32'h1);
    send(32'h1234_5678, 12'h7, 4'd3, 1'b0, 1'b0, 1'b0, 5'd0, "R8");

    // R7: default rejects every port
    wr(3'd4, 32'h3FF);
    send(32'h0000_0000, 12'h1, 4'd3, 1'b1, 1'b1, 1'b0, 5'd0, "R7");
    send(32'h0000_0000, 12'h1, 4'd12, 1'b1, 1'b1, 1'b0, 5'd0, "R7");

    // R1/R3: rule 0 accepts pages 0..3 from anyone
    put_rule(5'd0, 24'h003000, 24'hFFF000, 14'h1FFF);
    send(32'h003F_FFFF, 12'h5, 4'd0, 1'b1, 1'b0, 1'b1, 5'd0, "R3");
    send(32'h0000_0000, 12'h5, 4'd9, 1'b0, 1'b0, 1'b1, 5'd0, "R3");
    send(32'h0040_0000, 12'h5, 4'd0, 1'b1, 1'b1, 1'b0, 5'd0, "R3");

    // R4/R5: rule 5 rejects secure ids 0x10..0x20 on port 2
    put_rule(5'd5, 24'hFFF000, 24'h020010, 14'h2025);
    send(32'h1000_0000, 12'h010, 4'd2, 1'b1, 1'b1, 1'b1, 5'd5, "R4");
    send(32'h1000_0000, 12'h020, 4'd2, 1'b1, 1'b1, 1'b1, 5'd5, "R4");
    send(32'h1000_0000, 12'h021, 4'd2, 1'b1, 1'b1, 1'b0, 5'd0, "R4");
    send(32'h1000_0000, 12'h00F, 4'd2, 1'b1, 1'b1, 1'b0, 5'd0, "R4");
    send(32'h1000_0000, 12'h010, 4'd2, 1'b0, 1'b1, 1'b0, 5'd0, "R5");
    wr(3'd4, 32'h3FD);
    send(32'h1000_0000, 12'h010, 4'd1, 1'b1, 1'b0, 1'b0, 5'd0, "R7");
    send(32'h1000_0000, 12'h010, 4'd12, 1'b1, 1'b1, 1'b0, 5'd0, "R7");

    // R6: lower-numbered accept rule overrides rule 5
    put_rule(5'd3, 24'h1FF100, 24'hFFF000, 14'h1FFF);
    send(32'h1000_0000, 12'h010, 4'd2, 1'b1, 1'b0, 1'b1, 5'd3, "R6");

    // R2: read rule 5 back
    wr(3'd0, 32'h45); #1;
    chk(reg_rdata == 32'h45, "R2", "strobe visible", reg_rdata, 32'h45);
    @(negedge clk); #1;
    chk(reg_rdata == 32'h05, "R2", "strobe cleared", reg_rdata, 32'h05);
    rdchk(3'd1, 32'h00FFF000, "R2");
    rdchk(3'd2, 32'h00020010, "R2");
    rdchk(3'd3, 32'h00002025, "R2");

    // R1: rule number 20 ignores the copy strobe
    wr(3'd2, 32'hFFF000); wr(3'd3, 32'h1FFF);
    strobe(32'h34);
    send(32'h2000_0000, 12'h1, 4'd4, 1'b1, 1'b1, 1'b0, 5'd0, "R1");
    // R2: rule number 20 ignores the load strobe
    strobe(32'h54);
    rdchk(3'd3, 32'h00001FFF, "R2");

    // R10: zeroed rule 3 no longer decides
    put_rule(5'd3, 24'h0, 24'h0, 14'h0);
    send(32'h1000_0000, 12'h010, 4'd2, 1'b1, 1'b1, 1'b1, 5'd5, "R10");

    // R9: back-pressure
    @(negedge clk);
    resp_ready = 0;
    send(32'h0000_0000, 12'h0, 4'd0, 1'b0, 1'b0, 1'b1, 5'd0, "R9");
    txn_addr = 32'h0040_0000; txn_id = 12'h0; txn_port = 4'd0; txn_secure = 1; txn_valid = 1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      chk(resp_valid && !txn_ready && !resp_reject && resp_hit, "R9", "held verdict",
          {resp_valid, txn_ready, resp_reject, resp_hit}, 32'b1001);
    end
    @(negedge clk);
    resp_ready = 1;
    @(posedge clk); #2;
    chk(resp_valid && resp_reject && !resp_hit, "R9", "queued request",
        {resp_valid, resp_reject, resp_hit}, 32'b110);
    @(negedge clk);
    txn_valid = 0;

    // R8: second reset wipes the table
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    send(32'h1000_0000, 12'h010, 4'd2, 1'b1, 1'b0, 1'b0, 5'd0, "R8");
    rdchk(3'd1, 32'h0, "R8");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule